// File: doc/BRIEF.md
# Channel Status and User Bit Collector

This block sits behind a serial digital audio receiver and gathers the two side-channel bits that ride on every subframe: the channel-status bit and the user bit. For every sixteen subframes it builds one 32-bit status word. The word holds all sixteen user bits from both channels in arrival order, one channel-status byte taken only from the channel chosen by a select input, and a marker showing that the word began at the start of a status block. A status DMA channel or a register read then drains the word.

A finished word moves into a holding register and raises a not-empty flag. A one-cycle read strobe clears that flag. A newer word replaces an unread older one. Collection has its own enable, separate from the audio sample path. Dropping the enable discards any partly built word.

Top module: `csu_collector`

## Requirements
- R1: The status word places the 16 user bits in bits 15:0, the channel-status byte in bits 23:16 and the start-of-block marker in bit 24. Bits 31:25 are zero.
- R2: Every accepted subframe, whichever its channel, writes its user bit into the next user position, starting at bit 0. The sixteenth accepted subframe completes the word.
- R3: Only subframes of the selected channel supply channel-status bits. `cs_src_b` = 0 selects channel A (`sf_chan_b` = 0) and 1 selects channel B. The bits fill the status byte least significant bit first, and bits past the eighth are dropped.
- R4: Bit 24 is 1 only on a word whose first subframe carried `sf_block_start`. It is 0 on every other word.
- R5: A subframe flagged with `sf_block_start` discards the partly built word, and both fields restart at bit 0 with that subframe.
- R6: A completed word is visible on `status_word` with `status_ready` = 1 on the clock edge that accepts its last subframe, and not before.
- R7: `status_rd` clears `status_ready` at the next edge without changing `status_word`. A read while the flag is clear has no effect. A read in the same cycle as a new word leaves the flag set and holds the new word.
- R8: A word that completes while the previous one is unread replaces it.
- R9: While `collect_en` = 0, subframes are ignored, and the partly built word and its marker are discarded. The holding register and its flag are unaffected.
- R10: After reset, `status_ready` = 0 and `status_word` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| collect_en | input | 1 | Enables collection of status and user bits |
| cs_src_b | input | 1 | Channel-status source: 0 = channel A, 1 = channel B |
| sf_valid | input | 1 | One-cycle strobe: a received subframe is presented |
| sf_chan_b | input | 1 | Channel of the subframe: 0 = A, 1 = B |
| sf_cs_bit | input | 1 | Channel-status bit of the subframe |
| sf_user_bit | input | 1 | User bit of the subframe |
| sf_block_start | input | 1 | Subframe carries the block-start preamble |
| status_rd | input | 1 | Read strobe, clears the not-empty flag |
| status_word | output | 32 | Holding register with the assembled status word |
| status_ready | output | 1 | Not-empty flag of the holding register |

## Verification
Words are built from user patterns and from different channel-A and channel-B status bytes. A word that carries the wrong byte therefore shows whether the channel select, the bit order or the user interleave is at fault. The same stream is sent with channel A selected and then with channel B selected. A block start follows a few frames of all-ones garbage, so a missed restart shows up in both fields and in the marker. Runs with the enable low, two words in a row left unread, reads on an empty register, and a read that coincides with a new word separate the ignore, overwrite and read-priority rules.

// File: rtl/csu_pkg.sv
package csu_pkg;
    localparam int CSU_USER_W = 16;
    localparam int CSU_CS_W   = 8;
    localparam int CSU_WORD_W = 32;
    localparam int CSU_SOB_POS = CSU_USER_W + CSU_CS_W;
endpackage

// File: rtl/csu_bit_packer.sv
module csu_bit_packer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         restart,
    input  logic         push,
    input  logic         bit_in,
    output logic [W-1:0] data_now,
    output logic         fill_done
);
    localparam int CW = $clog2(W + 1);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(W);
    localparam logic [CW-1:0] LAST  = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  data;
    } pk_state_t;

    pk_state_t st_q, st_d, base;

    always_comb begin
        base      = restart ? '0 : st_q;
        data_now  = base.data;
        fill_done = 1'b0;
        st_d      = base;
        if (push && (base.cnt < LIMIT)) begin
            data_now[base.cnt[IW-1:0]] = bit_in;
            st_d.cnt  = base.cnt + 1'b1;
            fill_done = (base.cnt == LAST);
        end
        st_d.data = data_now;
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/csu_word_hold.sv
module csu_word_hold #(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] word_in,
    input  logic          rd,
    output logic [WW-1:0] word_out,
    output logic          ready
);
    typedef struct packed {
        logic          ready;
        logic [WW-1:0] word;
    } hold_t;

    hold_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.ready = 1'b1;
            h_d.word  = word_in;
        end else if (rd) begin
            h_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign word_out = h_q.word;
    assign ready    = h_q.ready;
endmodule

// File: rtl/csu_collector.sv
module csu_collector
    import csu_pkg::*;
#(
    parameter int USER_W = CSU_USER_W,
    parameter int CS_W   = CSU_CS_W,
    parameter int WORD_W = CSU_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              collect_en,
    input  logic              cs_src_b,
    input  logic              sf_valid,
    input  logic              sf_chan_b,
    input  logic              sf_cs_bit,
    input  logic              sf_user_bit,
    input  logic              sf_block_start,
    input  logic              status_rd,
    output logic [WORD_W-1:0] status_word,
    output logic              status_ready
);
    localparam int SOB_POS = USER_W + CS_W;
    localparam int PAD_W   = WORD_W - SOB_POS - 1;

    typedef struct packed {
        logic sob;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              accept;
    logic              cs_take;
    logic              blk_restart;
    logic              word_load;
    logic              flush;
    logic              cs_unused_done;
    logic              word_sob;
    logic [USER_W-1:0] user_now;
    logic [CS_W-1:0]   cs_now;
    logic [WORD_W-1:0] word_build;

    always_comb begin
        accept      = collect_en & sf_valid;
        cs_take     = accept & (sf_chan_b == cs_src_b);
        blk_restart = accept & sf_block_start;
    end

    assign flush = ~collect_en | word_load;

    csu_bit_packer #(.W(USER_W)) u_user (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .restart   (blk_restart),
        .push      (accept),
        .bit_in    (sf_user_bit),
        .data_now  (user_now),
        .fill_done (word_load)
    );

    csu_bit_packer #(.W(CS_W)) u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .restart   (blk_restart),
        .push      (cs_take),
        .bit_in    (sf_cs_bit),
        .data_now  (cs_now),
        .fill_done (cs_unused_done)
    );

    always_comb begin
        ctl_d    = ctl_q;
        word_sob = ctl_q.sob | blk_restart;
        if (blk_restart) begin
            ctl_d.sob = 1'b1;
        end
        if (flush) begin
            ctl_d.sob = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word_build = {{PAD_W{1'b0}}, word_sob, cs_now, user_now};
        end else begin : g_nopad
            assign word_build = {word_sob, cs_now, user_now};
        end
    endgenerate

    csu_word_hold #(.WW(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (word_load),
        .word_in  (word_build),
        .rd       (status_rd),
        .word_out (status_word),
        .ready    (status_ready)
    );
endmodule

// File: rtl/csu_collector_chk.sv
module csu_collector_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              collect_en,
    input logic              status_rd,
    input logic              status_ready,
    input logic [WORD_W-1:0] status_word,
    input logic              word_load
);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ready && status_rd && !word_load) |=> !status_ready);

    a_r7_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_ready) |-> $past(status_rd));

    a_r6_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |=> status_ready);

    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !word_load |=> $stable(status_word));

    a_r9_no_rise_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !collect_en |=> !$rose(status_ready));
endmodule

bind csu_collector csu_collector_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .collect_en   (collect_en),
    .status_rd    (status_rd),
    .status_ready (status_ready),
    .status_word  (status_word),
    .word_load    (word_load)
);

// File: tb/csu_collector_test.sv
`timescale 1ns/1ps
module csu_collector_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        collect_en = 1'b0;
    logic        cs_src_b = 1'b0;
    logic        sf_valid = 1'b0;
    logic        sf_chan_b = 1'b0;
    logic        sf_cs_bit = 1'b0;
    logic        sf_user_bit = 1'b0;
    logic        sf_block_start = 1'b0;
    logic        rd_mon = 1'b0;
    logic        rd_drv = 1'b0;
    logic        status_rd;
    logic [31:0] status_word;
    logic        status_ready;

    assign status_rd = rd_mon | rd_drv;

    always #5 clk = ~clk;

    csu_collector uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .collect_en     (collect_en),
        .cs_src_b       (cs_src_b),
        .sf_valid       (sf_valid),
        .sf_chan_b      (sf_chan_b),
        .sf_cs_bit      (sf_cs_bit),
        .sf_user_bit    (sf_user_bit),
        .sf_block_start (sf_block_start),
        .status_rd      (status_rd),
        .status_word    (status_word),
        .status_ready   (status_ready)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          mon_seen = 0;
    bit          mon_on = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] last_exp = '0;
    logic [31:0] prev_exp;

    // reference model state, built from the requirements
    logic [15:0] m_user = '0;
    logic [7:0]  m_cs = '0;
    int          m_upos = 0;
    int          m_cpos = 0;
    bit          m_sob = 1'b0;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_user = '0; m_cs = '0; m_upos = 0; m_cpos = 0; m_sob = 1'b0;
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic send_sf(input logic isb, input logic c, input logic u,
                           input logic bs, input logic rdx);
        @(negedge clk);
        sf_valid = 1'b1; sf_chan_b = isb; sf_cs_bit = c; sf_user_bit = u;
        sf_block_start = bs; rd_drv = rdx;
        if (collect_en) begin
            if (bs) begin
                model_clear();
                m_sob = 1'b1;
            end
            m_user[m_upos] = u;
            m_upos++;
            if (isb == cs_src_b && m_cpos < 8) begin
                m_cs[m_cpos] = c;
                m_cpos++;
            end
            if (m_upos == 16) begin
                last_exp = {7'b0, m_sob, m_cs, m_user};
                exp_q.push_back(last_exp);
                model_clear();
            end
        end
        @(negedge clk);
        sf_valid = 1'b0; sf_block_start = 1'b0; rd_drv = 1'b0;
    endtask

    task automatic send_frames(input logic [15:0] pat, input logic [7:0] ca,
                               input logic [7:0] cb, input logic bs, input int n);
        for (int k = 0; k < n; k++) begin
            send_sf(1'b0, ca[k], pat[2*k], bs && (k == 0), 1'b0);
            send_sf(1'b1, cb[k], pat[2*k+1], 1'b0, 1'b0);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_drv = 1'b1;
        @(negedge clk); rd_drv = 1'b0;
    endtask

    // monitor: pops expected words as the design delivers them
    initial begin
        forever begin
            @(negedge clk);
            rd_mon = 1'b0;
            if (mon_on && status_ready) begin
                mon_seen++;
                if (exp_q.size() == 0) begin
                    check32("R2 unexpected word", status_word, 32'hxxxx_xxxx);
                end else begin
                    check32("R1 R2 R3 R4 R5 word", status_word, exp_q.pop_front());
                end
                rd_mon = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check32("R10 ready after reset", {31'b0, status_ready}, 32'd0);
        check32("R10 word after reset", status_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        collect_en = 1'b1;
        cs_src_b = 1'b0;
        mon_on = 1'b1;

        // R3 channel A, R4 marker on first word only
        send_frames(16'hB38D, 8'hA5, 8'h3C, 1'b1, 8);
        send_frames(16'h0F1E, 8'h5A, 8'hC3, 1'b0, 8);
        // R3 channel B
        cs_src_b = 1'b1;
        send_frames(16'h7E81, 8'h96, 8'h2D, 1'b1, 8);
        // R5 partial word dropped by block start
        cs_src_b = 1'b0;
        send_frames(16'hFFFF, 8'hFF, 8'hFF, 1'b0, 5);
        send_frames(16'h1234, 8'h81, 8'h00, 1'b1, 8);
        repeat (4) @(negedge clk);
        check32("R2 words delivered", mon_seen, 32'd4);
        check32("R2 queue drained", exp_q.size(), 32'd0);

        // R9 disable discards partial and ignores subframes
        send_frames(16'hFFFF, 8'hFF, 8'hFF, 1'b1, 3);
        @(negedge clk);
        collect_en = 1'b0;
        model_clear();
        send_frames(16'hFFFF, 8'hFF, 8'hFF, 1'b1, 8);
        repeat (3) @(negedge clk);
        check32("R9 no word while disabled", {31'b0, status_ready}, 32'd0);
        check32("R9 nothing expected", exp_q.size(), 32'd0);
        collect_en = 1'b1;
        send_frames(16'hA0A0, 8'h0F, 8'hF0, 1'b0, 8);
        repeat (4) @(negedge clk);
        check32("R9 R4 restart after enable", mon_seen, 32'd5);

        // R8 overwrite of unread word
        mon_on = 1'b0;
        repeat (2) @(negedge clk);
        send_frames(16'h1111, 8'h11, 8'h22, 1'b0, 8);
        send_frames(16'h2222, 8'h33, 8'h44, 1'b0, 8);
        check32("R8 newest word kept", status_word, last_exp);
        check32("R8 ready set", {31'b0, status_ready}, 32'd1);
        exp_q.delete();

        // R7 read clears flag, word unchanged; read on empty has no effect
        pulse_rd();
        check32("R7 read clears ready", {31'b0, status_ready}, 32'd0);
        check32("R7 word kept after read", status_word, last_exp);
        pulse_rd();
        check32("R7 empty read ready", {31'b0, status_ready}, 32'd0);
        check32("R7 empty read word", status_word, last_exp);

        // R6 timing and R7 read coinciding with a new word
        send_frames(16'h5555, 8'h99, 8'h66, 1'b0, 8);
        prev_exp = last_exp;
        send_frames(16'h6666, 8'h77, 8'h88, 1'b0, 7);
        send_sf(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check32("R6 no early word", status_word, prev_exp);
        send_sf(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check32("R6 R7 new word wins over read", status_word, last_exp);
        check32("R7 ready kept with new word", {31'b0, status_ready}, 32'd1);
        check32("R1 top bits zero", {25'b0, status_word[31:25]}, 32'd0);
        exp_q.delete();
        finish_up();
    end
endmodule